// File: doc/BRIEF.md
# Fractional Clock-Enable Generator with Crystal Bypass

This block produces a single-cycle clock-enable strobe for one processor-class clock domain. Every rate is a pattern of enable pulses in one system clock. There are two reference strobes. One is a fast PLL-rate tick. The other is a slow crystal-rate tick; in the nominal setup the PLL tick rate is twenty times the crystal tick rate. When the PLL is powered down, its tick input simply stays low.

Normal mode uses the PLL path. That path first scales the PLL tick rate by 18/frac with a phase accumulator, then passes the result through an integer divider. A frac value of zero switches the scaling stage off, and the integer divider then counts raw PLL ticks. Bypass mode uses the crystal tick as the source. It then applies one of two settings: an integer divide, or a fractional rate of xfrac/32 produced by a second accumulator. A status output reports when the fractional stage is switched off.

All stage outputs merge into one output register. Every control input is a plain level. No input carries a data stream, so the block has no handshake.

Top module: `frac_clken_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `clk_en_o` and `frac_off_o` are 0.
- R2: With `bypass_i`=0 and `frac_i` in 18..255, the long-run pulse rate on `clk_en_o` equals the PLL tick rate × 18 / `frac_i` / N, within one pulse over the measured window. N is the integer divide value (0 and 1 both mean 1).
- R3: With `bypass_i`=0 and `frac_i`=0, the scaling stage is switched off and the rate is the PLL tick rate / N. `frac_off_o` is 1 exactly when `bypass_i`=0 and `frac_i`=0, and it follows the inputs with one cycle of delay.
- R4: A `frac_i` value from 1 to 17 is treated as 18, so the scaling stage never asks for more than one pulse per tick.
- R5: With `bypass_i`=1 and `xfrac_en_i`=0, the rate is the crystal tick rate / N.
- R6: With `bypass_i`=1 and `xfrac_en_i`=1, the rate is the crystal tick rate × `xfrac_i` / 32. In this mode `div_i` is unused, a value above 32 acts as 32, and a value of 0 yields no pulses.
- R7: The integer divider produces one pulse on every Nth input tick. The pulse appears on `clk_en_o` in the cycle after the clock edge that samples that tick.
- R8: The integer divider reads `div_i` only on the first tick of each output period. A change made later in the period takes effect from the next period.
- R9: `clk_en_o` is high only in a cycle that directly follows a cycle with a reference tick (PLL or crystal) at the input.
- R10: The tick of the path that is not selected is ignored. PLL ticks produce no pulses while `bypass_i`=1, and crystal ticks produce no pulses while `bypass_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| pll_tick_i | input | 1 | PLL-rate reference strobe |
| xtal_tick_i | input | 1 | Crystal-rate reference strobe |
| bypass_i | input | 1 | 1 selects the crystal source |
| frac_i | input | 8 | PLL scaling value (rate × 18/frac), 0 = stage off |
| div_i | input | 8 | Integer divide value, 0 or 1 = pass-through |
| xfrac_en_i | input | 1 | In bypass, 1 selects the xfrac/32 rate |
| xfrac_i | input | 6 | Crystal fractional numerator (over 32) |
| clk_en_o | output | 1 | Divided enable strobe |
| frac_off_o | output | 1 | PLL scaling stage switched off |

## Verification
The integer divider can finish a period and take in a new divide value in the same cycle. The bench provokes this by writing `div_i` part-way through a period and in the cycle of a period's closing tick. It judges the result by the exact pulse positions: the period in progress must keep its old length, and the following period must take the new one. Rate checks count pulses over long windows for several mixes of path, scaling value and divide value. Each count is compared with the rational rate computed by hand from R2–R6.

// File: rtl/clkfe_pkg.sv
package clkfe_pkg;
  localparam int FRAC_W   = 8;
  localparam int DIV_W    = 8;
  localparam int XFRAC_W  = 6;
  localparam int PLL_NUM  = 18;
  localparam int XTAL_DEN = 32;
endpackage

// File: rtl/clkfe_frac_scaler.sv
module clkfe_frac_scaler #(
  parameter int W     = 8,
  parameter int NUMER = 18
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         tick_i,
  input  logic [W-1:0] frac_i,
  output logic         tick_o
);
  localparam int AW = W + 1;

  logic [W-1:0]  held_q;
  logic [AW-1:0] acc_q;
  logic          fresh_q;
  logic [W-1:0]  frac_c, eff;
  logic [AW-1:0] sum;
  logic          hit;

  always_comb begin
    frac_c = (frac_i < W'(NUMER)) ? W'(NUMER) : frac_i;
    eff    = fresh_q ? frac_c : held_q;
    sum    = acc_q + AW'(NUMER);
    hit    = (sum >= {1'b0, eff});
    tick_o = tick_i && hit;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q   <= '0;
      held_q  <= W'(NUMER);
      fresh_q <= 1'b1;
    end else if (frac_i == '0) begin
      acc_q   <= '0;
      fresh_q <= 1'b1;
    end else if (tick_i) begin
      fresh_q <= 1'b0;
      acc_q   <= hit ? (sum - {1'b0, eff}) : sum;
      held_q  <= hit ? frac_c : eff;
    end
  end

  // R2
  frac_acc_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    acc_q < {1'b0, held_q});
endmodule

// File: rtl/clkfe_int_div.sv
module clkfe_int_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, held_q, eff;
  logic [W:0]   cnt_inc;
  logic         last;

  always_comb begin
    eff     = (cnt_q == '0) ? div_i : held_q;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    last    = (eff <= W'(1)) || (cnt_inc >= {1'b0, eff});
    tick_o  = tick_i && last;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      held_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == '0) held_q <= div_i;
      cnt_q <= last ? '0 : cnt_inc[W-1:0];
    end
  end

  // R8
  div_count_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q != '0) |-> (cnt_q < held_q));
endmodule

// File: rtl/clkfe_xtal_frac.sv
module clkfe_xtal_frac #(
  parameter int W   = 6,
  parameter int DEN = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         tick_i,
  input  logic [W-1:0] num_i,
  output logic         tick_o
);
  localparam int AW = W + 1;

  logic [AW-1:0] acc_q, sum;
  logic [W-1:0]  num_c;
  logic          hit;

  always_comb begin
    num_c  = (num_i > W'(DEN)) ? W'(DEN) : num_i;
    sum    = acc_q + {1'b0, num_c};
    hit    = (sum >= AW'(DEN));
    tick_o = tick_i && hit;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       acc_q <= '0;
    else if (tick_i) acc_q <= hit ? (sum - AW'(DEN)) : sum;
  end

  // R6
  xfrac_acc_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    acc_q < AW'(DEN));
endmodule

// File: rtl/frac_clken_gen.sv
module frac_clken_gen
  import clkfe_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               pll_tick_i,
  input  logic               xtal_tick_i,
  input  logic               bypass_i,
  input  logic [FRAC_W-1:0]  frac_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               xfrac_en_i,
  input  logic [XFRAC_W-1:0] xfrac_i,
  output logic               clk_en_o,
  output logic               frac_off_o
);
  logic pll_src, scaled_tick, pll_path, div_in, div_tick;
  logic xmode, xs_in, xs_tick, next_en;
  logic clk_en_q, frac_off_q;

  always_comb begin
    pll_src  = pll_tick_i && !bypass_i;
    pll_path = (frac_i == '0) ? pll_src : scaled_tick;
    xmode    = bypass_i && xfrac_en_i;
    xs_in    = xtal_tick_i && xmode;
    div_in   = bypass_i ? (xtal_tick_i && !xfrac_en_i) : pll_path;
    next_en  = xmode ? xs_tick : div_tick;
  end

  clkfe_frac_scaler #(.W(FRAC_W), .NUMER(PLL_NUM)) u_scaler (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(pll_src),
    .frac_i(frac_i), .tick_o(scaled_tick));

  clkfe_int_div #(.W(DIV_W)) u_div (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(div_in),
    .div_i(div_i), .tick_o(div_tick));

  clkfe_xtal_frac #(.W(XFRAC_W), .DEN(XTAL_DEN)) u_xfrac (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(xs_in),
    .num_i(xfrac_i), .tick_o(xs_tick));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      clk_en_q   <= 1'b0;
      frac_off_q <= 1'b0;
    end else begin
      clk_en_q   <= next_en;
      frac_off_q <= !bypass_i && (frac_i == '0);
    end
  end

  assign clk_en_o   = clk_en_q;
  assign frac_off_o = frac_off_q;

  // R9
  en_follows_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    clk_en_q |-> $past(pll_tick_i || xtal_tick_i));

  // R10
  bypass_ignores_pll_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(bypass_i && !xtal_tick_i) |-> !clk_en_q);

  // R10
  normal_ignores_xtal_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(!bypass_i && !pll_tick_i) |-> !clk_en_q);
endmodule

// File: tb/test_frac_clken_gen.sv
`timescale 1ns/1ps
module test_frac_clken_gen;
  typedef struct packed {
    logic       bp;
    logic [7:0] fr;
    logic [7:0] dv;
    logic       xe;
    logic [5:0] xf;
    int         expc;
  } vec_t;

  localparam int WIN = 3600;
  localparam int NV  = 11;
  // PLL tick every cycle, crystal tick every 20 cycles: 3600 and 180 ticks per window
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'd18, 8'd1, 1'b0, 6'd0,  3600}, // R2
    '{1'b0, 8'd36, 8'd1, 1'b0, 6'd0,  1800}, // R2
    '{1'b0, 8'd27, 8'd2, 1'b0, 6'd0,  1200}, // R2
    '{1'b0, 8'd0,  8'd3, 1'b0, 6'd0,  1200}, // R3
    '{1'b0, 8'd9,  8'd4, 1'b0, 6'd0,   900}, // R4
    '{1'b0, 8'd30, 8'd0, 1'b0, 6'd0,  2160}, // R7
    '{1'b1, 8'd18, 8'd3, 1'b0, 6'd0,    60}, // R5
    '{1'b1, 8'd18, 8'd7, 1'b1, 6'd16,   90}, // R6
    '{1'b1, 8'd18, 8'd5, 1'b1, 6'd40,  180}, // R6
    '{1'b1, 8'd18, 8'd2, 1'b1, 6'd0,     0}, // R6
    '{1'b1, 8'd18, 8'd1, 1'b1, 6'd8,    45}  // R6
  };

  logic clk = 0, rst = 1;
  logic pll_on = 0, pll_man = 0, xtal_on = 1;
  logic bypass = 0, xfrac_en = 0;
  logic [7:0] frac = 8'd18, div = 8'd1;
  logic [5:0] xfrac = '0;
  logic clk_en, frac_off;
  int   xcnt = 0;
  int   checks = 0, failures = 0;
  bit   done = 0;

  wire pll_tick  = pll_on | pll_man;
  wire xtal_tick = xtal_on && (xcnt == 0);

  always #2 clk = ~clk;
  always @(negedge clk) xcnt <= (xcnt == 19) ? 0 : xcnt + 1;

  frac_clken_gen i_frac_clken_gen (
    .clk_i(clk), .rst_i(rst), .pll_tick_i(pll_tick), .xtal_tick_i(xtal_tick),
    .bypass_i(bypass), .frac_i(frac), .div_i(div), .xfrac_en_i(xfrac_en),
    .xfrac_i(xfrac), .clk_en_o(clk_en), .frac_off_o(frac_off));

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic count_pulses(input int cyc, output int n);
    n = 0;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (clk_en) n++;
    end
  endtask

  // one manual PLL tick; returns clk_en in the cycle after the sampling edge
  task automatic pulse_pll(output logic en);
    pll_man = 1;
    @(negedge clk);
    pll_man = 0;
    en = clk_en;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    logic en;
    // R1 reset state
    @(negedge clk);
    check(clk_en == 0 && frac_off == 0, "R1 during reset", int'(clk_en), 0);
    do_reset();
    check(clk_en == 0 && frac_off == 0, "R1 after reset", int'(frac_off), 0);

    // rate table
    pll_on = 1;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      bypass = VEC[v].bp; frac = VEC[v].fr; div = VEC[v].dv;
      xfrac_en = VEC[v].xe; xfrac = VEC[v].xf;
      repeat (300) @(negedge clk);
      count_pulses(WIN, n);
      check(n >= VEC[v].expc - 1 && n <= VEC[v].expc + 1,
            $sformatf("R2-6 rate vector %0d", v), n, VEC[v].expc);
    end

    // R3 status pin
    @(negedge clk); bypass = 0; frac = 0;
    @(negedge clk);
    check(frac_off == 1, "R3 frac_off set", int'(frac_off), 1);
    bypass = 1;
    @(negedge clk);
    check(frac_off == 0, "R3 frac_off clear in bypass", int'(frac_off), 0);

    // R10 crystal ticks ignored in normal mode
    bypass = 0; frac = 8'd0; div = 8'd1; pll_on = 0; xfrac_en = 0;
    count_pulses(400, n);
    check(n == 0, "R10 xtal ignored", n, 0);
    // R10 PLL ticks ignored in bypass
    pll_on = 1; bypass = 1;
    repeat (40) @(negedge clk);
    count_pulses(400, n);
    check(n >= 19 && n <= 21, "R10 pll ignored", n, 20);

    // R7 exact pulse position, divide by 3
    xtal_on = 0; pll_on = 0; bypass = 0; frac = 0; div = 8'd3;
    do_reset();
    pulse_pll(en); check(en == 0, "R7 tick1", int'(en), 0);
    pulse_pll(en); check(en == 0, "R7 tick2", int'(en), 0);
    pulse_pll(en); check(en == 1, "R7 tick3", int'(en), 1);
    @(negedge clk);
    check(clk_en == 0, "R7 single pulse", int'(clk_en), 0);

    // R8 reload at period boundary
    div = 8'd4;
    do_reset();
    pulse_pll(en);
    div = 8'd2;
    pulse_pll(en); check(en == 0, "R8 old period t2", int'(en), 0);
    pulse_pll(en); check(en == 0, "R8 old period t3", int'(en), 0);
    pulse_pll(en); check(en == 1, "R8 old period end", int'(en), 1);
    pulse_pll(en); check(en == 0, "R8 new period t1", int'(en), 0);
    pulse_pll(en); check(en == 1, "R8 new period end", int'(en), 1);

    // R7 pass-through with value 1
    div = 8'd1;
    pulse_pll(en); check(en == 1, "R7 div1 pass", int'(en), 1);

    finish_run();
  end
endmodule